// File: doc/BRIEF.md
# Bus-Attached Serial Port (8N1)

This block is a simple asynchronous serial port placed on a single-cycle memory bus. A master (a processor or a hardware loader) talks to it through five word-aligned registers. These registers let the master switch the transmitter and the receiver on and off, set the bit period as a count of clock cycles, start sending a byte, read back the status, and fetch the last byte received. On the line side, the block drives a serial output that idles high and samples a serial input. Every frame has one low start bit, eight data bits sent least significant first, and one high stop bit.

Reads are combinational within the cycle of the request. Writes take effect at the next clock edge. Status reports whether a frame is being sent and whether a byte has arrived. The arrival flag stays set until the master writes zero to the status register. The master polls this flag; the block raises no interrupt.

Top module: `mmio_uart`

## Requirements
- R1: After reset, control reads 0, status reads 0, the divisor reads 0x1B8, the receive register reads 0 and the serial output is high.
- R2: Registers are decoded at these offsets from the base: control 0x00, status 0x04, divisor 0x08, transmit 0x0C, receive 0x10. Control bit 0 enables the transmitter and bit 1 enables the receiver. Status bit 0 is transmit busy and bit 1 is receive done. The transmit register and any unmapped offset read as 0. Read data is 0 in every cycle without a request.
- R3: A frame on the serial output is one low start bit, then eight data bits with bit 0 first, then one high stop bit. Each bit lasts divisor clock cycles, with a minimum of one. The line is high whenever no frame is being sent.
- R4: A write to the transmit register while the transmitter is enabled and idle starts a frame at the next clock edge, carrying write-data bits 7:0.
- R5: Status bit 0 reads 1 from the edge that accepts a transmit write until 10 × divisor cycles later, then reads 0.
- R6: A transmit write that arrives while status bit 0 is 1 is ignored. The frame in flight is unchanged and no second frame follows.
- R7: A transmit write while control bit 0 is 0 is ignored. No frame is sent and status bit 0 stays 0.
- R8: The serial input passes through a two-stage synchronizer. A falling edge starts a frame. The start bit is checked after half a divisor, and each later bit is sampled one divisor apart. A frame with a high stop bit stores its byte in receive bits 7:0, with bits 31:8 at zero, and sets status bit 1.
- R9: A low pulse that has ended by the mid-point of the start bit is rejected. No byte is stored and status bit 1 is not set.
- R10: A frame whose stop bit samples low is discarded. The receive register keeps its previous byte and status bit 1 is not set.
- R11: Status bit 1 stays set until a bus write of exactly 0 to the status register. A nonzero write to status leaves it set.
- R12: While control bit 1 is 0, incoming frames are ignored.
- R13: The divisor register is writable and reads back the value written. The value sets the bit period for both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus request for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the request cycle |
| txd_o | output | 1 | Serial output, idles high |
| rxd_i | input | 1 | Serial input, asynchronous |

## Verification
The bench sends and receives frames at several divisors, including odd ones. An off-by-one in the bit counter or a wrong sampling point would show as corrupted bits, or as busy clearing at the wrong time. It sends a second transmit write in the middle of a frame and a write while the transmitter is disabled. A design that accepted either would restart or garble the line, or send an extra frame. It drives a short start glitch, a frame with a low stop bit and a frame while the receiver is off, and checks that the flag and the stored byte stay unchanged. A design that trusted the falling edge alone would store garbage in these cases. Finally it writes a nonzero value and then zero to status, which separates a flag that is truly sticky from one cleared by any status write.

// File: rtl/mmuart_pkg.sv
package mmuart_pkg;
  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_STAT = 5'h04;
  localparam logic [4:0] OFS_DIV  = 5'h08;
  localparam logic [4:0] OFS_TXD  = 5'h0C;
  localparam logic [4:0] OFS_RXD  = 5'h10;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_STOP
  } phase_e;
endpackage

// File: rtl/mmuart_regs.sv
module mmuart_regs
  import mmuart_pkg::*;
#(
  parameter int              DIV_W     = 16,
  parameter int              DATA_W    = 8,
  parameter logic [31:0]     BASE_ADDR = 32'h0,
  parameter logic [DIV_W-1:0] RESET_DIV = DIV_W'(16'h01B8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [31:0]       addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tx_busy_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              tx_start_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              rx_done_o
);
  logic [1:0]       ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             done_q, done_d;
  logic             hit, wr;
  logic [4:0]       ofs;

  assign hit = req_i && (addr_i[31:5] == BASE_ADDR[31:5]);
  assign wr  = hit && we_i;
  assign ofs = addr_i[4:0];

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    done_d = done_q;
    if (wr && ofs == OFS_CTRL) ctrl_d = wdata_i[1:0];
    if (wr && ofs == OFS_DIV)  div_d  = wdata_i[DIV_W-1:0];
    if (rx_valid_i) begin
      done_d = 1'b1;
    end else if (wr && ofs == OFS_STAT && wdata_i == 32'h0) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 2'b00;
      div_q  <= RESET_DIV;
      done_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    rdata_o = 32'h0;
    if (hit && !we_i) begin
      case (ofs)
        OFS_CTRL: rdata_o = {30'h0, ctrl_q};
        OFS_STAT: rdata_o = {30'h0, done_q, tx_busy_i};
        OFS_DIV:  rdata_o = 32'(div_q);
        OFS_RXD:  rdata_o = 32'(rx_byte_i);
        default:  rdata_o = 32'h0;
      endcase
    end
  end

  assign tx_en_o    = ctrl_q[0];
  assign rx_en_o    = ctrl_q[1];
  assign div_o      = div_q;
  assign rx_done_o  = done_q;
  assign tx_start_o = wr && (ofs == OFS_TXD) && ctrl_q[0] && !tx_busy_i;
  assign tx_byte_o  = wdata_i[DATA_W-1:0];
endmodule

// File: rtl/mmuart_tx.sv
module mmuart_tx
  import mmuart_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              txd_o,
  output logic              busy_o
);
  localparam int            BC_W = $clog2(DATA_W);
  localparam logic [DIV_W:0] ONE = 1;

  phase_e            ph_q, ph_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              txd_q, txd_d;
  logic              bit_end;

  assign bit_end = ({1'b0, cnt_q} + ONE) >= {1'b0, div_i};

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    bc_d  = bc_q;
    sh_d  = sh_q;
    txd_d = txd_q;
    case (ph_q)
      PH_IDLE: begin
        txd_d = 1'b1;
        if (start_i) begin
          ph_d  = PH_START;
          cnt_d = '0;
          sh_d  = data_i;
          txd_d = 1'b0;
        end
      end
      PH_START: begin
        if (bit_end) begin
          ph_d  = PH_DATA;
          cnt_d = '0;
          bc_d  = '0;
          txd_d = sh_q[0];
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DATA: begin
        if (bit_end) begin
          cnt_d = '0;
          if (bc_q == BC_W'(DATA_W - 1)) begin
            ph_d  = PH_STOP;
            txd_d = 1'b1;
          end else begin
            bc_d  = bc_q + 1'b1;
            sh_d  = sh_q >> 1;
            txd_d = sh_q[1];
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        txd_d = 1'b1;
        if (bit_end) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      bc_q  <= '0;
      sh_q  <= '0;
      txd_q <= 1'b1;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      bc_q  <= bc_d;
      sh_q  <= sh_d;
      txd_q <= txd_d;
    end
  end

  assign txd_o  = txd_q;
  assign busy_o = (ph_q != PH_IDLE);
endmodule

// File: rtl/mmuart_rx.sv
module mmuart_rx
  import mmuart_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int             BC_W = $clog2(DATA_W);
  localparam logic [DIV_W:0] ONE  = 1;

  logic              sync1_q, sync2_q, prev_q;
  phase_e            ph_q, ph_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d;
  logic              full_end, half_end, fall;

  assign full_end = ({1'b0, cnt_q} + ONE) >= {1'b0, div_i};
  assign half_end = ({1'b0, cnt_q} + ONE) >= {2'b00, div_i[DIV_W-1:1]};
  assign fall     = prev_q && !sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= rxd_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    bc_d   = bc_q;
    sh_d   = sh_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    if (!en_i) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (fall) begin
            ph_d  = PH_START;
            cnt_d = '0;
          end
        end
        PH_START: begin
          if (half_end) begin
            cnt_d = '0;
            bc_d  = '0;
            ph_d  = sync2_q ? PH_IDLE : PH_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          if (full_end) begin
            cnt_d = '0;
            sh_d  = {sync2_q, sh_q[DATA_W-1:1]};
            if (bc_q == BC_W'(DATA_W - 1)) begin
              ph_d = PH_STOP;
            end else begin
              bc_d = bc_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (full_end) begin
            cnt_d = '0;
            ph_d  = PH_IDLE;
            if (sync2_q) begin
              vld_d  = 1'b1;
              byte_d = sh_q;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      bc_q   <= '0;
      sh_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      bc_q   <= bc_d;
      sh_q   <= sh_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  assign valid_o = vld_q;
  assign byte_o  = byte_q;
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import mmuart_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0,
  parameter int          DIV_W     = 16,
  parameter int          DATA_W    = 8,
  parameter int          RESET_DIV = 440
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_req_i,
  input  logic        bus_we_i,
  input  logic [31:0] bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        txd_o,
  input  logic        rxd_i
);
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(RESET_DIV);

  logic              tx_busy, tx_en, rx_en, tx_start, rx_valid, rx_done;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] tx_byte, rx_byte;

  mmuart_regs #(
    .DIV_W(DIV_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR), .RESET_DIV(DIV_INIT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .tx_busy_i(tx_busy), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .div_o(div),
    .tx_start_o(tx_start), .tx_byte_o(tx_byte), .rx_done_o(rx_done)
  );

  mmuart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tx_start), .data_i(tx_byte),
    .div_i(div), .txd_o(txd_o), .busy_o(tx_busy)
  );

  mmuart_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en), .rxd_i(rxd_i),
    .div_i(div), .valid_o(rx_valid), .byte_o(rx_byte)
  );
endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk
  import mmuart_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_req_i,
  input logic        bus_we_i,
  input logic [31:0] bus_addr_i,
  input logic [31:0] bus_wdata_i,
  input logic [31:0] bus_rdata_o,
  input logic        txd_o,
  input logic        tx_busy,
  input logic        tx_en,
  input logic        rx_valid,
  input logic        rx_done
);
  logic tx_wr, stat_clr;
  assign tx_wr    = bus_req_i && bus_we_i && (bus_addr_i == (BASE_ADDR | 32'(OFS_TXD)));
  assign stat_clr = bus_req_i && bus_we_i && (bus_addr_i == (BASE_ADDR | 32'(OFS_STAT)))
                    && (bus_wdata_i == 32'h0);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);                                              // R3
  AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> !txd_o);                                       // R3
  AST_WRITE_STARTS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr && tx_en && !tx_busy) |=> tx_busy);                        // R4
  AST_TX_OFF_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en && !tx_busy) |=> !tx_busy);                               // R7
  AST_RX_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid |=> rx_done);                                            // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && !stat_clr) |=> rx_done);                              // R11
  AST_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr && !rx_valid) |=> !rx_done);                            // R11
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i |-> (bus_rdata_o == 32'h0));                           // R2
endmodule

bind mmio_uart mmio_uart_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .txd_o(txd_o), .tx_busy(tx_busy), .tx_en(tx_en), .rx_valid(rx_valid),
  .rx_done(rx_done)
);

// File: tb/sim_mmio_uart.sv
module sim_mmio_uart;
  logic        clk, rst_n, req, we, rxd;
  logic [31:0] addr, wdata, rdata;
  logic        txd;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  // {divisor[15:0], byte[7:0]}
  localparam logic [23:0] VEC [6] = '{24'h0006_A5, 24'h0007_3C, 24'h0008_00,
                                      24'h000A_FF, 24'h000C_81, 24'h0010_5E};

  mmio_uart u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .txd_o(txd), .rxd_i(rxd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  // called right after the write that started the frame
  task automatic grab_tx(input int div, output logic [9:0] bits);
    repeat (div / 2) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < 10; i++) begin
      repeat (div) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  task automatic drive_rx(input logic [7:0] b, input int div, input logic stop);
    @(negedge clk);
    rxd = 0;
    repeat (div) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (div) @(negedge clk);
    end
    rxd = stop;
    repeat (div) @(negedge clk);
    rxd = 1;
    repeat (div + 8) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_up();
  end

  initial begin
    logic [31:0] r;
    logic [9:0]  bits;
    logic        hi;
    req = 0; we = 0; addr = 0; wdata = 0; rxd = 1; rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(32'h00, r); chk("R1 ctrl", r, 0);
    rd(32'h04, r); chk("R1 status", r, 0);
    rd(32'h08, r); chk("R1 divisor", r, 32'h1B8);
    rd(32'h10, r); chk("R1 rx", r, 0);
    chk("R1 txd", {31'h0, txd}, 1);
    // R2 unmapped and transmit offset read zero
    rd(32'h0C, r); chk("R2 tx reads 0", r, 0);
    rd(32'h14, r); chk("R2 unmapped", r, 0);

    wr(32'h00, 32'h3);
    rd(32'h00, r); chk("R2 ctrl readback", r, 3);

    foreach (VEC[k]) begin
      int          dv;
      logic [7:0]  b;
      dv = int'(VEC[k][23:8]);
      b  = VEC[k][7:0];
      wr(32'h08, 32'(dv));
      rd(32'h08, r); chk("R13 divisor readback", r, 32'(dv));
      wr(32'h0C, {24'hABCDEF, b});
      grab_tx(dv, bits);
      chk("R3 R4 tx frame", {22'h0, bits}, {22'h0, 1'b1, b, 1'b0});
      repeat (dv) @(negedge clk);
      drive_rx(~b, dv, 1'b1);
      rd(32'h04, r); chk("R8 status done", r, 2);
      rd(32'h10, r); chk("R8 rx byte", r, {24'h0, ~b});
      wr(32'h04, 0);
      rd(32'h04, r); chk("R11 clear", r, 0);
    end

    // R5 busy window at divisor 8: 80 cycles
    wr(32'h08, 8);
    wr(32'h0C, 32'h3C);
    rd(32'h04, r); chk("R5 busy set", r, 1);
    repeat (76) @(negedge clk);
    rd(32'h04, r); chk("R5 busy late", r, 1);
    repeat (3) @(negedge clk);
    rd(32'h04, r); chk("R5 busy cleared", r, 0);

    // R6 write during busy ignored
    wr(32'h0C, 32'hC3);
    wr(32'h0C, 32'h18);
    grab_tx(8, bits);
    chk("R6 first frame kept", {22'h0, bits}, {22'h0, 1'b1, 8'hC3, 1'b0});
    hi = 1;
    repeat (200) begin
      @(negedge clk);
      hi = hi & txd;
    end
    chk("R6 no second frame", {31'h0, hi}, 1);

    // R11 sticky flag
    drive_rx(8'h5A, 8, 1'b1);
    wr(32'h04, 32'h1);
    rd(32'h04, r); chk("R11 nonzero write keeps flag", r, 2);
    wr(32'h04, 32'h0);
    rd(32'h04, r); chk("R11 zero write clears", r, 0);

    // R9 start glitch
    @(negedge clk); rxd = 0;
    repeat (2) @(negedge clk); rxd = 1;
    repeat (120) @(negedge clk);
    rd(32'h04, r); chk("R9 glitch flag", r, 0);
    rd(32'h10, r); chk("R9 glitch byte", r, 32'h5A);

    // R10 low stop bit
    drive_rx(8'h11, 8, 1'b0);
    rd(32'h04, r); chk("R10 bad stop flag", r, 0);
    rd(32'h10, r); chk("R10 bad stop byte", r, 32'h5A);

    // R12 receiver disabled
    wr(32'h00, 32'h1);
    drive_rx(8'h77, 8, 1'b1);
    rd(32'h04, r); chk("R12 rx off flag", r, 0);
    rd(32'h10, r); chk("R12 rx off byte", r, 32'h5A);

    // R7 transmitter disabled
    wr(32'h00, 32'h2);
    wr(32'h0C, 32'h00);
    rd(32'h04, r); chk("R7 busy stays 0", r, 0);
    hi = 1;
    repeat (100) begin
      @(negedge clk);
      hi = hi & txd;
    end
    chk("R7 line idle", {31'h0, hi}, 1);

    // R2 no request gives zero read data
    @(negedge clk);
    req = 0; we = 0; addr = 32'h08;
    #1 chk("R2 idle rdata", rdata, 0);

    finish_up();
  end
endmodule